// File: doc/BRIEF.md
# Dynamic Rounding Shifter with Rectifier

This stage sits in a post-processing datapath and reshapes signed two's complement results one sample at a time. Each sample arrives with its own shift amount, shift direction and rectification mode. Because of this, software or upstream logic can apply a different scaling to every data point. This is the basis of dynamic range compression.

A right shift fills the vacated upper bits with copies of the sign bit. Before it truncates, it adds one half of the new least significant bit, so a result that lies exactly halfway always moves toward positive infinity. A left shift fills the vacated low bits with zeros. It never rounds, and it wraps silently when it overflows. After the shift, an optional rectifier either clamps negative values to zero (half-wave) or negates them (full-wave).

The stage has two register levels. The valid flag moves through the same two levels, so each result appears exactly two clocks after its sample, and back-to-back samples are accepted every cycle.

Top module: `dyn_round_shifter`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly two clock cycles. The result for a sample accepted at one rising edge appears on `out_data` after the second following edge.
- R2: When `shift_left` is 0 and `shift_amt` is n ≥ 1, the result is floor((x + 2^(n-1)) / 2^n). This is an arithmetic right shift with sign fill, rounded half toward positive infinity. For example, -2 shifted right by 2 gives 0, and -3 shifted right by 1 gives -1.
- R3: A `shift_amt` of 0 passes the sample through unshifted in either direction.
- R4: When `shift_left` is 1, the result is x·2^n reduced modulo 2^DATA_W and read as signed. The low bits are zero, no rounding is applied, and overflow is neither saturated nor flagged.
- R5: Shift amount, direction and rectify mode are taken per sample. A change between consecutive cycles affects only the sample it arrives with.
- R6: `rect_mode` 2'b00 (none) and the reserved code 2'b11 leave the shifted value unchanged.
- R7: `rect_mode` 2'b01 (half-wave) replaces a negative shifted value with 0 and leaves zero and positive values unchanged.
- R8: `rect_mode` 2'b10 (full-wave) replaces a negative shifted value with its two's complement negation. The most negative value wraps to itself.
- R9: After reset, `out_valid` and `out_data` are 0. While `out_valid` is 0, `out_data` holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample qualifier |
| in_data | input | DATA_W | Signed input sample |
| shift_amt | input | SHAMT_W | Shift distance for this sample |
| shift_left | input | 1 | 1 = left shift, 0 = right shift |
| rect_mode | input | 2 | 00 none, 01 half-wave, 10 full-wave, 11 none |
| out_valid | output | 1 | Result qualifier, two cycles after `in_valid` |
| out_data | output | DATA_W | Signed result |

## Verification
Every 8-bit input value is combined with every shift amount, both directions and all four rectify codes. The shift amount changes on every cycle, so a stage that holds a stale control value is caught.

Exact ties on negative inputs distinguish round-half-up from round-half-away-from-zero and from plain truncation. Left shifts of large magnitudes show that the result wraps rather than saturates. The value -128 under full-wave rectification shows that the negation wraps to itself.

Idle bubbles inserted into the stream check that the valid flag follows the two-cycle latency and that the output holds while no result is valid.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
  typedef enum logic [1:0] {
    RECT_NONE = 2'b00,
    RECT_HALF = 2'b01,
    RECT_FULL = 2'b10,
    RECT_RSVD = 2'b11
  } rect_mode_e;
endpackage

// File: rtl/rsr_shift_unit.sv
// Combinational arithmetic shifter: round-half-up on right shifts, zero fill on left shifts.
module rsr_shift_unit #(
  parameter int DATA_W  = 8,
  parameter int SHAMT_W = 3
) (
  input  logic [DATA_W-1:0]  din,
  input  logic [SHAMT_W-1:0] amt,
  input  logic               left,
  output logic [DATA_W-1:0]  dout
);
  // Headroom so that the rounding add and the largest left shift never lose bits.
  localparam int EXT_W = DATA_W + (1 << SHAMT_W) + 1;

  logic signed [EXT_W-1:0] ext;
  logic signed [EXT_W-1:0] half;
  logic signed [EXT_W-1:0] sum;
  logic signed [EXT_W-1:0] rsh;
  logic signed [EXT_W-1:0] lsh;

  always_comb begin
    ext  = EXT_W'($signed(din));
    half = '0;
    if (amt != '0) begin
      half = $signed({{(EXT_W-1){1'b0}}, 1'b1} << (amt - 1'b1));
    end
    sum  = ext + half;
    rsh  = sum >>> amt;
    lsh  = ext << amt;
    if (left) begin
      dout = lsh[DATA_W-1:0];
    end else begin
      dout = rsh[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/rsr_rectify_unit.sv
// Combinational rectifier: pass-through, half-wave clamp or full-wave negation.
module rsr_rectify_unit
  import rsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] din,
  input  rect_mode_e        mode,
  output logic [DATA_W-1:0] dout
);
  logic is_neg;

  always_comb begin
    is_neg = din[DATA_W-1];
    unique case (mode)
      RECT_HALF: dout = is_neg ? '0 : din;
      RECT_FULL: dout = is_neg ? (~din + 1'b1) : din;
      default:   dout = din;
    endcase
  end
endmodule

// File: rtl/dyn_round_shifter.sv
// Two-stage pipeline: the shift result is registered, then rectified and registered.
module dyn_round_shifter
  import rsr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SHAMT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [SHAMT_W-1:0] shift_amt,
  input  logic               shift_left,
  input  logic [1:0]         rect_mode,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_data
);
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] rectified;

  logic              s1_valid_q, s1_valid_d;
  logic [DATA_W-1:0] s1_data_q,  s1_data_d;
  rect_mode_e        s1_mode_q,  s1_mode_d;
  logic              s1_en;

  logic              s2_valid_q, s2_valid_d;
  logic [DATA_W-1:0] s2_data_q,  s2_data_d;
  logic              s2_en;

  rsr_shift_unit #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .din  (in_data),
    .amt  (shift_amt),
    .left (shift_left),
    .dout (shifted)
  );

  rsr_rectify_unit #(.DATA_W(DATA_W)) u_rect (
    .din  (s1_data_q),
    .mode (s1_mode_q),
    .dout (rectified)
  );

  // Next-state logic
  always_comb begin
    s1_en      = in_valid;
    s1_valid_d = in_valid;
    s1_data_d  = shifted;
    s1_mode_d  = rect_mode_e'(rect_mode);
    s2_en      = s1_valid_q;
    s2_valid_d = s1_valid_q;
    s2_data_d  = rectified;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_data_q  <= '0;
      s1_mode_q  <= RECT_NONE;
      s2_valid_q <= 1'b0;
      s2_data_q  <= '0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s2_valid_q <= s2_valid_d;
      if (s1_en) begin
        s1_data_q <= s1_data_d;
        s1_mode_q <= s1_mode_d;
      end
      if (s2_en) begin
        s2_data_q <= s2_data_d;
      end
    end
  end

  assign out_valid = s2_valid_q;
  assign out_data  = s2_data_q;
endmodule

// File: rtl/dyn_round_shifter_chk.sv
module dyn_round_shifter_chk
  import rsr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SHAMT_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [DATA_W-1:0]  in_data,
  input logic [SHAMT_W-1:0] shift_amt,
  input logic               shift_left,
  input logic [1:0]         rect_mode,
  input logic               out_valid,
  input logic [DATA_W-1:0]  out_data
);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  // Cycles since reset, saturating at 2, so that $past never reaches into reset.
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= 2'd0;
    end else if (age_q != 2'd2) begin
      age_q <= age_q + 2'd1;
    end
  end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  assert_zero_shift_passes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2 && out_valid && $past(shift_amt, 2) == '0 &&
     ($past(rect_mode, 2) == RECT_NONE || $past(rect_mode, 2) == RECT_RSVD))
    |-> (out_data == $past(in_data, 2)));

  assert_left_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2 && out_valid && $past(shift_left, 2) && $past(shift_amt, 2) != '0 &&
     $past(rect_mode, 2) == RECT_NONE)
    |-> (out_data[0] == 1'b0));

  assert_half_nonneg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2 && out_valid && $past(rect_mode, 2) == RECT_HALF)
    |-> (out_data[DATA_W-1] == 1'b0));

  assert_full_nonneg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2 && out_valid && $past(rect_mode, 2) == RECT_FULL)
    |-> (out_data[DATA_W-1] == 1'b0 || out_data == MOST_NEG));

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && !out_valid) |-> $stable(out_data));
endmodule

bind dyn_round_shifter dyn_round_shifter_chk #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_data    (in_data),
  .shift_amt  (shift_amt),
  .shift_left (shift_left),
  .rect_mode  (rect_mode),
  .out_valid  (out_valid),
  .out_data   (out_data)
);

// File: tb/dyn_round_shifter_test.sv
module dyn_round_shifter_test;
  localparam int DATA_W  = 8;
  localparam int SHAMT_W = 3;

  logic               clk;
  logic               rst_n;
  logic               in_valid;
  logic [DATA_W-1:0]  in_data;
  logic [SHAMT_W-1:0] shift_amt;
  logic               shift_left;
  logic [1:0]         rect_mode;
  logic               out_valid;
  logic [DATA_W-1:0]  out_data;

  int n_checks;
  int n_fail;
  bit done;

  // Expected-value pipeline: stage 1 holds the newest applied sample.
  bit         e1_v, e2_v;
  logic [7:0] e1_d, e2_d;
  string      e1_t, e2_t;
  logic [7:0] last_out;

  dyn_round_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .shift_amt  (shift_amt),
    .shift_left (shift_left),
    .rect_mode  (rect_mode),
    .out_valid  (out_valid),
    .out_data   (out_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference arithmetic taken from the requirements.
  function automatic logic [7:0] model(logic [7:0] x, int amt, bit left, int mode);
    int v;
    int r;
    int d;
    int t;
    logic [7:0] r8;
    v = int'($signed(x));
    if (left) begin
      r = v * (1 << amt);
    end else if (amt == 0) begin
      r = v;
    end else begin
      d = 1 << amt;
      t = v + d / 2;
      r = t / d;
      if (t < 0 && (t % d) != 0) r = r - 1;
    end
    r8 = r[7:0];
    if (mode == 1 && r8[7]) r8 = 8'd0;
    else if (mode == 2 && r8[7]) r8 = 8'(-int'($signed(r8)));
    return r8;
  endfunction

  function automatic string tag_of(int amt, bit left, int mode);
    if (mode == 2) return "R8";
    if (mode == 1) return "R7";
    if (mode == 3) return "R6";
    if (amt == 0)  return "R3";
    if (left)      return "R4";
    return "R2";
  endfunction

  task automatic report(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, $signed(act), $signed(exp));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  // One cycle: check the result due now, then drive the next sample.
  task automatic step(bit v, logic [7:0] x, int amt, bit left, int mode);
    @(negedge clk);
    report(out_valid == e2_v, "R1", {7'd0, out_valid}, {7'd0, e2_v});
    if (e2_v) begin
      report(out_data == e2_d, {e2_t, "/R5"}, out_data, e2_d);
      last_out = e2_d;
    end else begin
      report(out_data == last_out, "R9", out_data, last_out);
    end
    e2_v = e1_v; e2_d = e1_d; e2_t = e1_t;
    e1_v = v;
    e1_d = model(x, amt, left, mode);
    e1_t = tag_of(amt, left, mode);
    in_valid   = v;
    in_data    = x;
    shift_amt  = SHAMT_W'(amt);
    shift_left = left;
    rect_mode  = 2'(mode);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int cnt;
    n_checks = 0; n_fail = 0; done = 1'b0;
    e1_v = 1'b0; e2_v = 1'b0; e1_d = '0; e2_d = '0; e1_t = "R9"; e2_t = "R9";
    last_out = 8'd0;
    in_valid = 1'b0; in_data = '0; shift_amt = '0; shift_left = 1'b0; rect_mode = 2'b00;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    report(out_valid == 1'b0, "R9", {7'd0, out_valid}, 8'd0);
    report(out_data == 8'd0, "R9", out_data, 8'd0);
    rst_n = 1'b1;

    // Directed corners: tie toward +inf, left wrap, most negative under full-wave.
    step(1'b1, 8'hFE, 2, 1'b0, 0);   // R2: -2 >> 2 = 0
    step(1'b1, 8'hFD, 1, 1'b0, 0);   // R2: -3 >> 1 = -1
    step(1'b1, 8'h7F, 1, 1'b1, 0);   // R4: 127 << 1 wraps to -2
    step(1'b1, 8'h80, 0, 1'b0, 2);   // R8: -128 stays -128
    step(1'b0, 8'h55, 3, 1'b1, 1);   // R9 bubble
    step(1'b1, 8'h81, 0, 1'b0, 1);   // R7: -127 clamps to 0

    // Exhaustive sweep; shift amount changes every cycle (R5), with periodic bubbles.
    cnt = 0;
    for (int x = 0; x < 256; x++) begin
      for (int m = 0; m < 4; m++) begin
        for (int dir = 0; dir < 2; dir++) begin
          for (int a = 0; a < (1 << SHAMT_W); a++) begin
            cnt++;
            if (cnt % 13 == 0) step(1'b0, 8'(x ^ 8'h5A), a, dir[0], m);
            step(1'b1, 8'(x), a, dir[0], m);
          end
        end
      end
    end
    step(1'b0, '0, 0, 1'b0, 0);
    step(1'b0, '0, 0, 1'b0, 0);
    step(1'b0, '0, 0, 1'b0, 0);
    finish_run();
  end
endmodule